// File: doc/BRIEF.md
# Protected fuse read controller

This block holds a small one-time-programmable fuse array, modelled as registers, and lets a host reach it over a simple valid/ready register bus with a 12-bit byte address and 32-bit data. The low part of the array is public. The host reads public words directly, as 32-bit words, from a window that starts at byte address 0x200. Words at or above the public limit read as zero through that window.

Every word, public or not, can also be read through an indirect sequence. The host writes a command word to the control register at 0x040. The command carries a fuse byte offset, an unlock code and a start flag. The block then spends a fixed number of cycles on the fetch and places the word in the result register at 0x060. It clears the read flag itself, and the host polls that flag to see that the fetch is done.

A program sequence works the same way. It ORs the key-data register at 0x050 into the addressed fuse word, so a fuse bit can only move from 0 to 1.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset, the control, key-data and result registers read 0. Each fuse byte holds its own byte address, so word w reads {4w+3, 4w+2, 4w+1, 4w}, with the lowest byte in bits [7:0].
- R2: The control word carries the fuse byte offset in bits [23:16], the unlock code in [15:8], the read flag in bit 1 and the program flag in bit 0. A control write whose unlock field is not 0xAC is ignored: the flags stay clear, the result is unchanged, and the control register reads back unchanged.
- R3: An accepted read sets the read flag for exactly 8 cycles. In the cycle the flag clears, the result register holds the fuse word at offset[7:2]; offset bits [1:0] are ignored.
- R4: An accepted program ORs the key-data value, as it stood when the command was accepted, into the addressed word. The program flag reads 1 for exactly 16 cycles. Fuse bits never go from 1 to 0.
- R5: While either flag is set, every write to the control register is ignored. This holds even with the correct unlock code.
- R6: A command with both flags set performs only the read; the fuse array is not changed.
- R7: A window read at 0x200 + 4w returns word w when w < 48 and returns 0 otherwise. Every word, protected ones included, is readable through the indirect read.
- R8: Reads of unmapped addresses, of misaligned addresses, or at 0x300 and above return 0. Writes to the result register or to the window have no effect.
- R9: req_ready_o is always 1. A read request gets rsp_valid_o with its data in the next cycle. A write gets no response.
- R10: The offset field is 8 bits wide, so the highest offset 0xFF reads word 63.
- R11: Control readback shows {8'h0, offset, unlock code} from the last accepted command, together with the live read flag in bit 1 and program flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus ready, always 1 |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata_o | output | 32 | Read data |

## Verification
Two events can fall in the same cycle, and the bench provokes both.

The first is the completion of a program and a window read of the word being programmed. The bench starts a program and then issues window reads of that word back to back. The read sampled on the completing edge must return the old word, and the next read must return the ORed word.

The second is the completion of a read and a read of the result register. The bench polls the control and result registers through the whole busy window. A behavioural reference model, run on every clock, judges each response against the value held before that edge.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int CTRL_ADDR = 'h040;
  localparam int KEY_ADDR  = 'h050;
  localparam int RES_ADDR  = 'h060;
  localparam int WIN_BASE  = 'h200;
  localparam logic [7:0] UNLOCK_CODE = 8'hAC;

  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_PROG} op_e;

  // factory content: every byte holds its own byte address
  function automatic logic [31:0] fuse_init(input int w);
    fuse_init = {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)};
  endfunction
endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int WORDS  = 64,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  win_idx_i,
  output logic [DATA_W-1:0] win_data_o,
  input  logic [IDX_W-1:0]  seq_idx_i,
  output logic [DATA_W-1:0] seq_data_o,
  input  logic              pg_en_i,
  input  logic [DATA_W-1:0] pg_data_i
);
  logic [DATA_W-1:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[w] <= DATA_W'(fuse_pkg::fuse_init(w));
      else if (pg_en_i && seq_idx_i == IDX_W'(w))   mem_q[w] <= mem_q[w] | pg_data_i;
    end

    AST_FUSE_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_q[w] & $past(mem_q[w])) == $past(mem_q[w])); // R4
  end

  assign win_data_o = mem_q[win_idx_i];
  assign seq_data_o = mem_q[seq_idx_i];
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
#(
  parameter int RD_LAT = 8,
  parameter int PG_LAT = 16,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  localparam int MAX_LAT = (RD_LAT > PG_LAT) ? RD_LAT : PG_LAT,
  localparam int CNT_W   = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_rd_i,
  input  logic              start_pg_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] key_data_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              pg_en_o,
  output logic [DATA_W-1:0] pg_data_o,
  output logic [DATA_W-1:0] res_o,
  output logic              rd_busy_o,
  output logic              pg_busy_o
);
  op_e               op_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] pd_q, res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      pd_q  <= '0;
      res_q <= '0;
    end else if (op_q == OP_IDLE) begin
      if (start_rd_i) begin
        op_q  <= OP_READ;
        cnt_q <= CNT_W'(RD_LAT - 1);
        idx_q <= idx_i;
      end else if (start_pg_i) begin
        op_q  <= OP_PROG;
        cnt_q <= CNT_W'(PG_LAT - 1);
        idx_q <= idx_i;
        pd_q  <= key_data_i;
      end
    end else if (cnt_q == '0) begin
      if (op_q == OP_READ) res_q <= arr_data_i;
      op_q <= OP_IDLE;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign idx_o     = idx_q;
  assign pg_en_o   = (op_q == OP_PROG) && (cnt_q == '0);
  assign pg_data_o = pd_q;
  assign res_o     = res_q;
  assign rd_busy_o = (op_q == OP_READ);
  assign pg_busy_o = (op_q == OP_PROG);

  AST_RD_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_READ) |-> (int'(cnt_q) < RD_LAT)); // R3
  AST_RD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_READ && cnt_q == '0) |=> (op_q == OP_IDLE && res_q == $past(arr_data_i))); // R3
  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_READ) |=> $stable(res_q)); // R2
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl
  import fuse_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int WORDS     = 64,
  parameter int PUB_WORDS = 48,
  parameter int RD_LAT    = 8,
  parameter int PG_LAT    = 16,
  localparam int IDX_W    = $clog2(WORDS),
  localparam int WIN_SPAN = 4 * WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  logic              is_wr, is_rd, busy, key_ok, ctrl_wr, ctrl_take;
  logic              hit_ctrl, hit_key, hit_res, hit_win, mapped;
  logic [ADDR_W-1:0] win_rel;
  logic [IDX_W-1:0]  win_idx;
  logic [7:0]        off_q, code_q;
  logic [DATA_W-1:0] key_data_q, win_data, seq_data, pg_data, res, rd_mux;
  logic [IDX_W-1:0]  seq_idx;
  logic              pg_en, rd_busy, pg_busy, start_rd, start_pg;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  assign req_ready_o = 1'b1;
  assign is_wr = req_valid_i && req_we_i;
  assign is_rd = req_valid_i && !req_we_i;

  assign hit_ctrl = (req_addr_i == ADDR_W'(CTRL_ADDR));
  assign hit_key  = (req_addr_i == ADDR_W'(KEY_ADDR));
  assign hit_res  = (req_addr_i == ADDR_W'(RES_ADDR));
  assign win_rel  = req_addr_i - ADDR_W'(WIN_BASE);
  assign hit_win  = (req_addr_i >= ADDR_W'(WIN_BASE)) && (win_rel < ADDR_W'(WIN_SPAN))
                    && (win_rel[1:0] == 2'b00);
  assign win_idx  = win_rel[IDX_W+1:2];
  assign mapped   = hit_ctrl || hit_key || hit_res || hit_win;

  assign busy      = rd_busy || pg_busy;
  assign key_ok    = (req_wdata_i[15:8] == UNLOCK_CODE);
  assign ctrl_wr   = is_wr && hit_ctrl;
  assign ctrl_take = ctrl_wr && key_ok && !busy;
  assign start_rd  = ctrl_take && req_wdata_i[1];
  assign start_pg  = ctrl_take && req_wdata_i[0] && !req_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q      <= '0;
      code_q     <= '0;
      key_data_q <= '0;
    end else begin
      if (ctrl_take) begin
        off_q  <= req_wdata_i[23:16];
        code_q <= req_wdata_i[15:8];
      end
      if (is_wr && hit_key) key_data_q <= req_wdata_i;
    end
  end

  fuse_array #(.WORDS(WORDS), .DATA_W(DATA_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_idx_i  (win_idx),
    .win_data_o (win_data),
    .seq_idx_i  (seq_idx),
    .seq_data_o (seq_data),
    .pg_en_i    (pg_en),
    .pg_data_i  (pg_data)
  );

  fuse_seq #(.RD_LAT(RD_LAT), .PG_LAT(PG_LAT), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_rd_i (start_rd),
    .start_pg_i (start_pg),
    .idx_i      (req_wdata_i[18+IDX_W-1:18]),
    .key_data_i (key_data_q),
    .arr_data_i (seq_data),
    .idx_o      (seq_idx),
    .pg_en_o    (pg_en),
    .pg_data_o  (pg_data),
    .res_o      (res),
    .rd_busy_o  (rd_busy),
    .pg_busy_o  (pg_busy)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)     rd_mux = DATA_W'({8'h00, off_q, code_q, 6'b0, rd_busy, pg_busy});
    else if (hit_key) rd_mux = key_data_q;
    else if (hit_res) rd_mux = res;
    else if (hit_win && (int'(win_idx) < PUB_WORDS)) rd_mux = win_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= is_rd;
      rsp_rdata_q <= is_rd ? rd_mux : '0;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  AST_START_NEEDS_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(ctrl_wr && key_ok)); // R2
  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && busy) |=> ($stable(off_q) && $stable(code_q))); // R5
  AST_ONE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_busy && pg_busy)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && !mapped) |=> (rsp_rdata_o == '0)); // R8
  AST_RSP_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rd |=> rsp_valid_o); // R9
  AST_NO_WR_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R9
endmodule

// File: tb/fuse_rd_ctrl_tb.sv
module fuse_rd_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [11:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [31:0] rsp_rdata_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  fuse_rd_ctrl u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_mem [64];
  int          m_op;      // 0 idle, 1 read, 2 program
  int          m_cnt, m_idx;
  logic [31:0] m_pd, m_res, m_kd, m_rd;
  logic [7:0]  m_off, m_code;
  bit          m_rv;

  function automatic logic [31:0] m_read(input int a);
    if (a == 'h040) return {8'h00, m_off, m_code, 6'b0, m_op == 1, m_op == 2};
    if (a == 'h050) return m_kd;
    if (a == 'h060) return m_res;
    if (a >= 'h200 && a < 'h300 && (a % 4) == 0) begin
      if ((a - 'h200) / 4 < 48) return m_mem[(a - 'h200) / 4];
    end
    return 32'h0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < 64; w++) m_mem[w] = {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)};
      m_op = 0; m_cnt = 0; m_idx = 0; m_pd = 0; m_res = 0; m_kd = 0;
      m_off = 0; m_code = 0; m_rv = 0; m_rd = 0;
    end else begin
      bit          was_busy;
      logic [31:0] kd_pre;
      m_rv = req_valid_i && !req_we_i;
      m_rd = m_rv ? m_read(int'(req_addr_i)) : 32'h0;
      was_busy = (m_op != 0);
      kd_pre = m_kd;
      if (m_op != 0) begin
        if (m_cnt == 0) begin
          if (m_op == 1) m_res = m_mem[m_idx];
          else           m_mem[m_idx] = m_mem[m_idx] | m_pd;
          m_op = 0;
        end else m_cnt--;
      end
      if (req_valid_i && req_we_i && req_addr_i == 12'h040 &&
          req_wdata_i[15:8] == 8'hAC && !was_busy) begin
        m_off  = req_wdata_i[23:16];
        m_code = req_wdata_i[15:8];
        if (req_wdata_i[1]) begin
          m_op = 1; m_cnt = 7; m_idx = int'(req_wdata_i[23:18]);
        end else if (req_wdata_i[0]) begin
          m_op = 2; m_cnt = 15; m_idx = int'(req_wdata_i[23:18]); m_pd = kd_pre;
        end
      end
      if (req_valid_i && req_we_i && req_addr_i == 12'h050) m_kd = req_wdata_i;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk({31'b0, req_ready_o}, 32'h1, "R9 ready");
      chk({31'b0, rsp_valid_o}, {31'b0, m_rv}, "R9 rsp_valid vs model");
      chk(rsp_rdata_o, m_rd, "R9 rdata vs model");
    end
  end

  // ---------------- bus tasks (called at a negedge) ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req_valid_i = 1'b1; req_we_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    req_valid_i = 1'b1; req_we_i = 1'b0; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    d = rsp_rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // count the polls that see the given flag bit set
  task automatic poll_flag(input int bitpos, output int n);
    logic [31:0] v;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      rd(12'h040, v);
      if (v[bitpos]) n++;
      else break;
    end
  endtask

  initial begin
    logic [31:0] v;
    int n;
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    rd(12'h040, v); chk(v, 32'h0, "R1 ctrl reset");
    rd(12'h050, v); chk(v, 32'h0, "R1 key reset");
    rd(12'h060, v); chk(v, 32'h0, "R1 result reset");
    rd(12'h200, v); chk(v, 32'h03020100, "R1 word0 content");
    rd(12'h204, v); chk(v, 32'h07060504, "R1 word1 content");

    // R2 wrong unlock code ignored
    wr(12'h040, 32'h00105502);
    rd(12'h040, v); chk(v, 32'h0, "R2 wrong code ctrl unchanged");
    idle(10);
    rd(12'h060, v); chk(v, 32'h0, "R2 wrong code result unchanged");

    // R3 indirect read, 8 cycle busy window
    wr(12'h040, 32'h0034AC02);
    poll_flag(1, n); chk(32'(n), 32'd8, "R3 read flag cycles");
    rd(12'h060, v); chk(v, 32'h37363534, "R3 read result");
    rd(12'h040, v); chk(v, 32'h0034AC00, "R11 ctrl readback after read");

    // R3 offset low bits ignored
    wr(12'h040, 32'h0036AC02); idle(10);
    rd(12'h060, v); chk(v, 32'h37363534, "R3 offset bits [1:0] ignored");

    // R10 highest offset
    wr(12'h040, 32'h00FFAC02); idle(10);
    rd(12'h060, v); chk(v, 32'hFFFEFDFC, "R10 offset 0xFF word 63");

    // R7 protected words hidden from window, reachable indirectly
    rd(12'h2C8, v); chk(v, 32'h0, "R7 protected word in window");
    rd(12'h2BC, v); chk(v, 32'hBFBEBDBC, "R7 last public word");
    wr(12'h040, 32'h00C8AC02); idle(10);
    rd(12'h060, v); chk(v, 32'hCBCAC9C8, "R7 protected word indirect");

    // R4 program with 16 cycle busy window
    wr(12'h050, 32'h80000001);
    wr(12'h040, 32'h0004AC01);
    wr(12'h050, 32'h0000FF00); // later key write must not affect it
    poll_flag(0, n); chk(32'(n), 32'd15, "R4 program flag cycles after key write");
    rd(12'h204, v); chk(v, 32'h87060505, "R4 OR into word1");
    rd(12'h040, v); chk(v, 32'h0004AC00, "R11 ctrl readback after program");

    // R5 control writes ignored while busy
    wr(12'h040, 32'h0008AC02);
    wr(12'h040, 32'h0010AC01);
    idle(12);
    rd(12'h040, v); chk(v, 32'h0008AC00, "R5 busy write ignored ctrl");
    rd(12'h060, v); chk(v, 32'h0B0A0908, "R5 read result intact");
    rd(12'h210, v); chk(v, 32'h13121110, "R5 no program happened");

    // R6 both flags: read only
    wr(12'h050, 32'hFFFFFFFF);
    wr(12'h040, 32'h000CAC03);
    idle(20);
    rd(12'h060, v); chk(v, 32'h0F0E0D0C, "R6 both flags read result");
    rd(12'h20C, v); chk(v, 32'h0F0E0D0C, "R6 both flags array untouched");

    // R8 unmapped and read-only targets
    rd(12'h044, v); chk(v, 32'h0, "R8 unmapped 0x044");
    rd(12'h100, v); chk(v, 32'h0, "R8 unmapped 0x100");
    rd(12'h300, v); chk(v, 32'h0, "R8 above window");
    rd(12'h202, v); chk(v, 32'h0, "R8 misaligned window");
    wr(12'h060, 32'h12345678);
    rd(12'h060, v); chk(v, 32'h0F0E0D0C, "R8 result write ignored");
    wr(12'h200, 32'hFFFFFFFF);
    rd(12'h200, v); chk(v, 32'h03020100, "R8 window write ignored");

    // concurrency: window read on the edge a program completes
    wr(12'h050, 32'h00F00000);
    wr(12'h040, 32'h0014AC01);
    for (int i = 1; i <= 17; i++) begin
      rd(12'h214, v);
      if (i == 16) chk(v, 32'h17161514, "R4 old word on completing edge");
      if (i == 17) chk(v, 32'h17F61514, "R4 new word after completion");
    end

    // concurrency: result polled through a read completion
    wr(12'h040, 32'h0018AC02);
    for (int i = 1; i <= 9; i++) begin
      rd(12'h060, v);
      if (i == 8) chk(v, 32'h0F0E0D0C, "R3 old result on completing edge");
      if (i == 9) chk(v, 32'h1B1A1918, "R3 new result after completion");
    end

    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule